// File: doc/BRIEF.md
# One-Shot Masked Port Change Detector

This block watches a group of seven general-purpose port levels and raises a latched
interrupt when any watched level moves away from the value it held when the detector
was armed. Software arms it by writing the configuration register with its enable bit
set. That write records a reference copy of the seven levels. Each of the seven levels
can be included in or excluded from the comparison through a mask register.

Detection fires once. The first mismatch on an unmasked level sets a sticky status
bit and disarms the comparator. Any access to the mask register, whether a read or a
write, clears the status bit. A fresh arming write is then needed before another
event can be caught. The status bit can also drive the pin of the highest port as an
active-high interrupt, provided that port is configured as an output. Port levels pass
through a synchronizer before they are compared.

Top module: `tdet_top`

## Requirements
- R1: After reset the mask reads as all zeros, the status bit is 0, and detection is off: a change on any port level leaves the status bit at 0.
- R2: A mask write stores write data bits 6:0 and ignores bit 7. While the mask read strobe is high, the read value carries the status bit in bit 7 and the mask in bits 6:0. Mask bit i enables monitoring of port level bit i.
- R3: Every configuration write with data bit 7 set records the synchronized port levels as the new reference, arms detection and clears the status bit, whether or not detection was already armed.
- R4: While armed, a difference between any unmasked synchronized level and its reference bit sets the status bit. Differences on masked bits have no effect.
- R5: Once set, the status bit stays set when further changes occur and when the levels return to their reference values.
- R6: A mask read or a mask write clears the status bit at the end of the access. Two successive reads after an event return bit 7 as 1 and then 0.
- R7: Once an event has been cleared, or detection has been disarmed by a mask access, later changes do not set the status bit until a new arming write.
- R8: A configuration write with data bit 7 clear disarms detection and leaves the status bit unchanged.
- R9: The interrupt pin equals the status bit when the highest port's mode is 2'b01 (output) and is 0 for the modes 2'b00, 2'b10 and 2'b11.
- R10: A level change held for at least two clock cycles is caught. The status bit rises on the third rising clock edge after the input changes, because two synchronizer stages and the status register lie on the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_lvl | input | 7 | Raw port levels; bit i is the i-th watched port |
| p31_mode | input | 2 | Configuration code of the interrupt-capable port (01 = output) |
| mask_wr | input | 1 | Write strobe for the mask register |
| mask_rd | input | 1 | Read strobe for the mask register |
| cfg_wr | input | 1 | Write strobe for the configuration register |
| wr_data | input | 8 | Write data shared by both registers |
| mask_rdata | output | 8 | Read value: status in bit 7, mask in bits 6:0 |
| irq_flag | output | 1 | Status bit |
| irq_pin | output | 1 | Active-high interrupt pin drive |

## Verification
The assertions assume that each register strobe lasts one cycle for each access and
that wr_data is valid whenever a write strobe is high. They also assume that reset is
held low for at least one clock edge. The bench changes every input only on falling
edges and pulses each strobe for exactly one cycle. Before an arming write, it holds
the port levels steady for three cycles, so the reference copy matches the levels it
programmed. It does not try to catch pulses shorter than two cycles, since their
capture is not guaranteed.

// File: rtl/tdet_pkg.sv
package tdet_pkg;

  localparam int WATCH_W = 7;
  localparam int REG_W   = 8;

  typedef enum logic [1:0] {
    PM_RESERVED = 2'b00,
    PM_OUTPUT   = 2'b01,
    PM_INPUT    = 2'b10,
    PM_INPUT_PU = 2'b11
  } pin_mode_e;

  // true when an unmasked level differs from its reference bit
  function automatic logic tdet_mismatch(
    input logic [WATCH_W-1:0] lvl,
    input logic [WATCH_W-1:0] ref_bits,
    input logic [WATCH_W-1:0] mask
  );
    return |((lvl ^ ref_bits) & mask);
  endfunction

  // read value: status on top, mask below
  function automatic logic [REG_W-1:0] tdet_readback(
    input logic               status,
    input logic [WATCH_W-1:0] mask
  );
    logic [REG_W-1:0] v;
    v = '0;
    v[REG_W-1]     = status;
    v[WATCH_W-1:0] = mask;
    return v;
  endfunction

endpackage

// File: rtl/tdet_sync.sv
module tdet_sync #(
  parameter int WIDTH  = 7,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= '0;
          else        stage_q[g] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= '0;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign d_out = stage_q[STAGES-1];

endmodule

// File: rtl/tdet_snap_cmp.sv
module tdet_snap_cmp
  import tdet_pkg::*;
#(
  parameter int W = WATCH_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_sync,
  input  logic [W-1:0] mask,
  input  logic         arm_ev,      // config write with enable set
  input  logic         cfg_off_ev,  // config write with enable clear
  input  logic         mask_acc_ev, // any mask read or write
  output logic         armed,
  output logic         hit
);

  logic [W-1:0] snap_q;
  logic         armed_q;
  logic         mism_w;

  assign mism_w = tdet_mismatch(lvl_sync, snap_q, mask);
  assign hit    = armed_q & mism_w & ~arm_ev & ~cfg_off_ev & ~mask_acc_ev;
  assign armed  = armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
    end else if (arm_ev) begin
      snap_q <= lvl_sync;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (arm_ev) begin
      armed_q <= 1'b1;
    end else if (cfg_off_ev || mask_acc_ev || hit) begin
      armed_q <= 1'b0;
    end
  end

  // R3: arming leaves the detector armed with the levels recorded
  p_arm_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    arm_ev |=> (armed_q && snap_q == $past(lvl_sync)));

  // R7: a mask access without arming disarms
  p_mask_disarms_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_acc_ev && !arm_ev) |=> !armed_q);

  // R8: clearing the enable disarms
  p_cfg_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_off_ev && !arm_ev) |=> !armed_q);

  // R3: reference copy moves only on an arming write
  p_snap_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_ev |=> $stable(snap_q));

endmodule

// File: rtl/tdet_status.sv
module tdet_status
  import tdet_pkg::*;
#(
  parameter int W  = WATCH_W,
  parameter int RW = REG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mask_wr,
  input  logic          mask_rd,
  input  logic [RW-1:0] wr_data,
  input  logic          arm_ev,
  input  logic          hit,
  input  logic [1:0]    p31_mode,
  output logic [W-1:0]  mask,
  output logic          status,
  output logic          mask_acc_ev,
  output logic [RW-1:0] rdata,
  output logic          irq_pin
);

  logic [W-1:0] mask_q;
  logic         status_q;
  pin_mode_e    mode_w;

  assign mask_acc_ev = mask_wr | mask_rd;
  assign mode_w      = pin_mode_e'(p31_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_wr) begin
      mask_q <= wr_data[W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= 1'b0;
    end else if (arm_ev || mask_acc_ev) begin
      status_q <= 1'b0;
    end else if (hit) begin
      status_q <= 1'b1;
    end
  end

  assign mask    = mask_q;
  assign status  = status_q;
  assign rdata   = mask_rd ? tdet_readback(status_q, mask_q) : '0;
  assign irq_pin = (mode_w == PM_OUTPUT) ? status_q : 1'b0;

  // R6: a mask access clears the status bit
  p_acc_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mask_acc_ev |=> !status_q);

  // R5: status is sticky until cleared
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q && !arm_ev && !mask_acc_ev) |=> status_q);

  // R3: arming clears the status bit
  p_arm_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    arm_ev |=> !status_q);

  // R4: status rises only after a hit from the comparator
  p_rise_from_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q) |-> $past(hit));

  // R2: mask write keeps the low bits only
  p_mask_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> mask_q == $past(wr_data[W-1:0]));

endmodule

// File: rtl/tdet_top.sv
module tdet_top
  import tdet_pkg::*;
#(
  parameter int W           = WATCH_W,
  parameter int RW          = REG_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  port_lvl,
  input  logic [1:0]    p31_mode,
  input  logic          mask_wr,
  input  logic          mask_rd,
  input  logic          cfg_wr,
  input  logic [RW-1:0] wr_data,
  output logic [RW-1:0] mask_rdata,
  output logic          irq_flag,
  output logic          irq_pin
);

  localparam int EN_BIT = RW - 1;

  logic [W-1:0] lvl_sync_w;
  logic [W-1:0] mask_w;
  logic         arm_ev_w;
  logic         cfg_off_ev_w;
  logic         mask_acc_ev_w;
  logic         hit_w;
  logic         armed_w;
  logic         status_w;

  assign arm_ev_w     = cfg_wr &  wr_data[EN_BIT];
  assign cfg_off_ev_w = cfg_wr & ~wr_data[EN_BIT];

  tdet_sync #(.WIDTH(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (port_lvl),
    .d_out (lvl_sync_w)
  );

  tdet_snap_cmp #(.W(W)) u_cmp (
    .clk         (clk),
    .rst_n       (rst_n),
    .lvl_sync    (lvl_sync_w),
    .mask        (mask_w),
    .arm_ev      (arm_ev_w),
    .cfg_off_ev  (cfg_off_ev_w),
    .mask_acc_ev (mask_acc_ev_w),
    .armed       (armed_w),
    .hit         (hit_w)
  );

  tdet_status #(.W(W), .RW(RW)) u_stat (
    .clk         (clk),
    .rst_n       (rst_n),
    .mask_wr     (mask_wr),
    .mask_rd     (mask_rd),
    .wr_data     (wr_data),
    .arm_ev      (arm_ev_w),
    .hit         (hit_w),
    .p31_mode    (p31_mode),
    .mask        (mask_w),
    .status      (status_w),
    .mask_acc_ev (mask_acc_ev_w),
    .rdata       (mask_rdata),
    .irq_pin     (irq_pin)
  );

  assign irq_flag = status_w;

  // R7: no event can be raised while disarmed
  p_disarmed_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_w |=> !$rose(status_w));

  // R4: the detector disarms itself once an event is taken
  p_one_shot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_w) |-> !armed_w);

endmodule

// File: tb/sim_tdet_top.sv
`timescale 1ns/1ps
module sim_tdet_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] port_lvl = '0;
  logic [1:0] p31_mode = 2'b01;
  logic       mask_wr = 1'b0;
  logic       mask_rd = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] mask_rdata;
  logic       irq_flag;
  logic       irq_pin;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tdet_top u0 (
    .clk(clk), .rst_n(rst_n), .port_lvl(port_lvl), .p31_mode(p31_mode),
    .mask_wr(mask_wr), .mask_rd(mask_rd), .cfg_wr(cfg_wr), .wr_data(wr_data),
    .mask_rdata(mask_rdata), .irq_flag(irq_flag), .irq_pin(irq_pin)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ports(input logic [6:0] v);
    @(negedge clk);
    port_lvl = v;
  endtask

  task automatic wr_mask(input logic [7:0] d);
    @(negedge clk);
    mask_wr = 1'b1; wr_data = d;
    @(negedge clk);
    mask_wr = 1'b0;
  endtask

  task automatic wr_cfg(input logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; wr_data = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd_mask(output logic [7:0] v);
    @(negedge clk);
    mask_rd = 1'b1;
    #1 v = mask_rdata;
    @(negedge clk);
    mask_rd = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [6:0] base;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);

    // R1: reset state and no detection before arming
    chk(irq_flag == 1'b0, "R1 flag", irq_flag, 0);
    chk(irq_pin == 1'b0, "R1 pin", irq_pin, 0);
    set_ports(7'h7F);
    wait_n(5);
    chk(irq_flag == 1'b0, "R1 unarmed change", irq_flag, 0);
    rd_mask(v);
    chk(v == 8'h00, "R1 mask reset", v, 0);

    // R2: bit 7 ignored on write, readback layout
    wr_mask(8'hFF);
    rd_mask(v);
    chk(v == 8'h7F, "R2 readback", v, 8'h7F);
    wr_mask(8'h2A);
    rd_mask(v);
    chk(v == 8'h2A, "R2 readback2", v, 8'h2A);

    // R10: exact latency of a detected change
    wr_mask(8'h7F);
    set_ports(7'h00);
    wait_n(3);
    wr_cfg(8'h80);
    set_ports(7'h01);
    wait_n(2);
    chk(irq_flag == 1'b0, "R10 before third edge", irq_flag, 0);
    wait_n(1);
    chk(irq_flag == 1'b1, "R10 third edge", irq_flag, 1);

    // R5: more changes and revert keep status
    set_ports(7'h13);
    wait_n(3);
    set_ports(7'h00);
    wait_n(4);
    chk(irq_flag == 1'b1, "R5 sticky", irq_flag, 1);

    // R9: pin follows status only in output mode
    for (int md = 0; md < 4; md++) begin
      @(negedge clk);
      p31_mode = 2'(md);
      #1 chk(irq_pin == (md == 1), "R9 mode sweep", irq_pin, (md == 1));
    end
    @(negedge clk) p31_mode = 2'b01;

    // R8: enable-clear write keeps status set
    wr_cfg(8'h00);
    chk(irq_flag == 1'b1, "R8 status kept", irq_flag, 1);

    // R6: two reads give 1 then 0
    rd_mask(v);
    chk(v == 8'hFF, "R6 first read", v, 8'hFF);
    rd_mask(v);
    chk(v == 8'h7F, "R6 second read", v, 8'h7F);
    #1 chk(irq_pin == 1'b0, "R9 pin cleared", irq_pin, 0);

    // R7: no new event after clear until rearm
    set_ports(7'h40);
    wait_n(5);
    chk(irq_flag == 1'b0, "R7 disarmed after clear", irq_flag, 0);

    // R3: rearm with status set clears it and takes a fresh reference
    wait_n(2);
    wr_cfg(8'h80);
    set_ports(7'h00);
    wait_n(4);
    chk(irq_flag == 1'b1, "R3 armed detects", irq_flag, 1);
    set_ports(7'h55);
    wait_n(3);
    wr_cfg(8'h80);
    wait_n(1);
    chk(irq_flag == 1'b0, "R3 rearm clears", irq_flag, 0);
    wait_n(5);
    chk(irq_flag == 1'b0, "R3 new reference", irq_flag, 0);
    wr_cfg(8'h80);
    set_ports(7'h54);
    wait_n(4);
    chk(irq_flag == 1'b1, "R3 repeated arm", irq_flag, 1);

    // R8: enable clear disarms
    wr_mask(8'h7F);
    set_ports(7'h00);
    wait_n(3);
    wr_cfg(8'h80);
    wr_cfg(8'h00);
    set_ports(7'h7F);
    wait_n(5);
    chk(irq_flag == 1'b0, "R8 disarmed", irq_flag, 0);

    // R7: mask write disarms an armed detector
    set_ports(7'h00);
    wait_n(3);
    wr_cfg(8'h80);
    wr_mask(8'h7F);
    set_ports(7'h7F);
    wait_n(5);
    chk(irq_flag == 1'b0, "R7 mask write disarms", irq_flag, 0);

    // R4 R5 R6 R10: sweep every mask against a two-cycle pulse on every bit
    for (int m = 0; m < 128; m++) begin
      for (int b = 0; b < 7; b++) begin
        base = 7'((m * 5 + b * 19) & 8'h7F);
        wr_mask(8'(m) | 8'h80);
        set_ports(base);
        wait_n(3);
        wr_cfg(8'h80);
        set_ports(base ^ (7'h01 << b));
        wait_n(1);
        set_ports(base);
        wait_n(4);
        chk(irq_flag == m[b], "R4 sweep flag", irq_flag, m[b]);
        rd_mask(v);
        chk(v == {m[b], 7'(m)}, "R6 sweep read", v, {m[b], 7'(m)});
        rd_mask(v);
        chk(v[7] == 1'b0, "R6 sweep reread", v[7], 0);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule